// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block is a bank of up to 32 general-purpose pins with a word-wide register port. Software can set up each pin on its own as a plain input, a driven output or an interrupt source. Interrupt sources can fire on an active level, on a single edge or on both edges. A per-pin polarity bit chooses between active-high and active-low, or between rising and falling. Pad inputs pass through a two-flop synchroniser. Each interrupt pin records its events in a latched status bit. The status is gated by an enable vector, and the result is ORed into one interrupt line.

Software acknowledges an event by writing ones to a clear register. Interrupts are enabled through a set-style register, where ones enable. They are disabled through a mask register, where zeros disable and ones leave the pin unchanged. A data read returns the driven value for output pins and the synchronised pad value for input pins. The bank is configured by a pin-count parameter. A count of zero, or a count above 32, is treated as 32. Pins above the count read as zero and never drive.

Top module: `gpio_irq_bank`

## Requirements
- R1: The effective pin count is the parameter value when it is 1 to 32, and 32 when it is 0 or larger than 32. Pins at or above the effective count read as 0, never set `padOe`, and cannot be enabled.
- R2: After reset, every register reads 0, `padOut` and `padOe` are 0, and `irqOut` is 0.
- R3: `padOut` equals the output-data register (byte address 0x04). A `padOe` bit is 1 only when its direction bit (0x08, 1 = output) is 1 and its mode bit (0x0C, 1 = interrupt) is 0.
- R4: A read of the data register (0x00) returns the output-data bit for pins whose direction bit is 1. For other pins it returns the pad value after two clock edges of synchronisation.
- R5: Writing to the enable-set register (0x28) sets the enable bit for every 1 in the data. Writing to the mask register (0x24) clears the enable bit for every 0 in the data and leaves the pins written with 1 unchanged. The mask register reads back the enable vector.
- R6: When a pin has its mode bit set, its edge bit set (0x14, 1 = edge) and its both-edge bit clear (0x18), a rising transition of the synchronised input sets its status bit (0x1C) if polarity (0x10) is 0. A falling transition sets it if polarity is 1. The bit stays set until it is cleared.
- R7: When a pin is in interrupt mode with edge and both-edge selected, either transition sets its status bit, whatever its polarity.
- R8: In level mode (mode bit 1, edge bit 0), the status bit follows the synchronised input XOR polarity. A clear write leaves it set while that level is still active.
- R9: Writing to the clear register (0x20) clears each status bit written with 1. Zero bits have no effect.
- R10: `irqOut` is 1 exactly when some pin has both its status bit and its enable bit set.
- R11: A pin whose mode bit is 0 never sets its status bit from pad activity.
- R12: Registers sit at byte offsets 0x00 to 0x28 in steps of 4. A write takes effect at the clock edge that samples `wrEn`. Accesses with a nonzero `addr[1:0]`, or beyond 0x28, are ignored. The clear and enable-set registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| padIn | input | 32 | Pad input levels |
| padOut | output | 32 | Output-data drive values |
| padOe | output | 32 | Per-pin output enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every clock cycle. Each register write strobe is one-hot. Enable-set and mask writes take effect the next cycle with the correct polarity. The output-data register reaches `padOut` one cycle after a write. An edge-mode status bit never drops without a clear write or a change of mode. Some behaviour only the bench's scenarios can show. These are the polarity and both-edge choice of which transition counts, level-mode status following the pad through a clear, and the synchroniser latency seen at the data register. They also include the width fallback for a zero pin count and the inert upper pins of a narrow bank.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W   = 32;
  localparam int MAX_PINS = 32;
  localparam int LAST_IDX = 10;

  typedef enum logic [3:0] {
    RI_PADS   = 4'd0,
    RI_DRIVE  = 4'd1,
    RI_DIR    = 4'd2,
    RI_MODE   = 4'd3,
    RI_POL    = 4'd4,
    RI_EDGE   = 4'd5,
    RI_BOTH   = 4'd6,
    RI_STAT   = 4'd7,
    RI_ACK    = 4'd8,
    RI_MASK   = 4'd9,
    RI_UNMASK = 4'd10
  } regIdx_t;

  typedef struct packed {
    logic              wrDrive;
    logic              wrDir;
    logic              wrMode;
    logic              wrPol;
    logic              wrEdge;
    logic              wrBoth;
    logic              wrAck;
    logic              wrMask;
    logic              wrUnmask;
    logic [WORD_W-1:0] data;
  } strobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  output strobes_t          strb,
  output regIdx_t           rdIdx,
  output logic              addrHit
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] wordIdx;

  assign wordIdx = addr[ADDR_W-1:2];
  assign rdIdx   = regIdx_t'(wordIdx[3:0]);
  assign addrHit = (addr[1:0] == 2'b00) && (int'(wordIdx) <= LAST_IDX);

  always_comb begin
    strb      = '0;
    strb.data = wrData;
    if (wrEn && addrHit) begin
      case (rdIdx)
        RI_DRIVE:  strb.wrDrive  = 1'b1;
        RI_DIR:    strb.wrDir    = 1'b1;
        RI_MODE:   strb.wrMode   = 1'b1;
        RI_POL:    strb.wrPol    = 1'b1;
        RI_EDGE:   strb.wrEdge   = 1'b1;
        RI_BOTH:   strb.wrBoth   = 1'b1;
        RI_ACK:    strb.wrAck    = 1'b1;
        RI_MASK:   strb.wrMask   = 1'b1;
        RI_UNMASK: strb.wrUnmask = 1'b1;
        default:   ;
      endcase
    end
  end

  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDrive, strb.wrDir, strb.wrMode, strb.wrPol, strb.wrEdge,
              strb.wrBoth, strb.wrAck, strb.wrMask, strb.wrUnmask}));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  regIdx_t           rdIdx,
  input  logic              addrHit,
  input  logic [WORD_W-1:0] padIn,
  output logic [WORD_W-1:0] padOut,
  output logic [WORD_W-1:0] padOe,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);
  localparam logic [WORD_W:0]   ONE_AT = (WORD_W + 1)'(1) << NPINS;
  localparam logic [WORD_W-1:0] VALID  = WORD_W'(ONE_AT - 1'b1);

  logic [WORD_W-1:0] driveQ, dirQ, modeQ, polQ, edgeQ, bothQ, enQ, statQ;
  logic [WORD_W-1:0] sync1Q, sync2Q, prevQ, statNext, wMasked;
  logic              cfgTouch;

  assign wMasked  = strb.data & VALID;
  assign cfgTouch = strb.wrAck | strb.wrMode | strb.wrEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveQ <= '0; dirQ <= '0; modeQ <= '0; polQ <= '0;
      edgeQ  <= '0; bothQ <= '0; enQ <= '0;
    end else begin
      if (strb.wrDrive) driveQ <= wMasked;
      if (strb.wrDir)   dirQ   <= wMasked;
      if (strb.wrMode)  modeQ  <= wMasked;
      if (strb.wrPol)   polQ   <= wMasked;
      if (strb.wrEdge)  edgeQ  <= wMasked;
      if (strb.wrBoth)  bothQ  <= wMasked;
      if (strb.wrMask)        enQ <= enQ & wMasked;
      else if (strb.wrUnmask) enQ <= enQ | wMasked;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0; sync2Q <= '0; prevQ <= '0; statQ <= '0;
    end else begin
      sync1Q <= padIn & VALID;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
      statQ  <= statNext;
    end
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_pin
    if (i < NPINS) begin : g_live
      logic adjNow, adjPrev, evt, ackBit;
      assign adjNow  = sync2Q[i] ^ polQ[i];
      assign adjPrev = prevQ[i] ^ polQ[i];
      assign ackBit  = strb.wrAck & strb.data[i];
      assign evt     = bothQ[i] ? (sync2Q[i] != prevQ[i]) : (adjNow & ~adjPrev);
      assign statNext[i] = !modeQ[i] ? (statQ[i] & ~ackBit)
                         : !edgeQ[i] ? adjNow
                         : (evt | (statQ[i] & ~ackBit));

      // R6
      edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (statQ[i] && modeQ[i] && edgeQ[i] && !cfgTouch) |=> statQ[i]);
    end else begin : g_idle
      assign statNext[i] = 1'b0;
    end
  end

  assign padOut = driveQ;
  assign padOe  = dirQ & ~modeQ;
  assign irqOut = |(statQ & enQ);

  always_comb begin
    rdData = '0;
    if (addrHit) begin
      case (rdIdx)
        RI_PADS:  rdData = (dirQ & driveQ) | (~dirQ & sync2Q);
        RI_DRIVE: rdData = driveQ;
        RI_DIR:   rdData = dirQ;
        RI_MODE:  rdData = modeQ;
        RI_POL:   rdData = polQ;
        RI_EDGE:  rdData = edgeQ;
        RI_BOTH:  rdData = bothQ;
        RI_STAT:  rdData = statQ;
        RI_MASK:  rdData = enQ;
        default:  rdData = '0;
      endcase
    end
  end

  // R5
  unmask_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrUnmask |=> ((enQ & $past(wMasked)) == $past(wMasked)));
  // R5
  mask_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> ((enQ & ~$past(strb.data)) == '0));
  // R3
  drive_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDrive |=> (padOut == $past(wMasked)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       padIn,
  output logic [31:0]       padOut,
  output logic [31:0]       padOe,
  output logic              irqOut
);
  // R1: out-of-range counts fall back to the full bank
  localparam int NPINS = (PIN_COUNT <= 0 || PIN_COUNT > MAX_PINS) ? MAX_PINS : PIN_COUNT;

  strobes_t strb;
  regIdx_t  rdIdx;
  logic     addrHit;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .rdIdx(rdIdx), .addrHit(addrHit)
  );

  gpio_bank_dp #(.NPINS(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdx(rdIdx), .addrHit(addrHit),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int A_PADS = 0, A_DRIVE = 4, A_DIR = 8, A_MODE = 12, A_POL = 16,
                 A_EDGE = 20, A_BOTH = 24, A_STAT = 28, A_ACK = 32, A_MASK = 36,
                 A_UNMASK = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0, padIn = '0;
  logic [31:0] rd0, out0, oe0, rd1, out1, oe1;
  logic irq0, irq1;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(0)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rd0),
    .padIn(padIn), .padOut(out0), .padOe(oe0), .irqOut(irq0));
  gpio_irq_bank #(.PIN_COUNT(8)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rd1),
    .padIn(padIn), .padOut(out1), .padOe(oe1), .irqOut(irq1));

  function automatic logic [31:0] expOe(logic [31:0] dir, logic [31:0] mode);
    return dir & ~mode;
  endfunction
  function automatic logic [31:0] expData(logic [31:0] dir, logic [31:0] drv, logic [31:0] pad);
    return (dir & drv) | (~dir & pad);
  endfunction
  function automatic logic expEvt(logic both, logic pol, logic s0, logic s1);
    if (both) return s0 != s1;
    return (s1 ^ pol) & ~(s0 ^ pol);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = 6'(a); wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); addr = 6'(a); #1; v = rd0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R2 watchdog act=%h exp=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state of all registers and outputs
    for (int a = 0; a <= 40; a += 4) begin
      rd(a, v); chk("R2 reg", v, 32'h0);
    end
    chk("R2 oe", oe0, 0); chk("R2 out", out0, 0); chk("R2 irq", {31'b0, irq0}, 0);

    // R12 write timing: unchanged before the sampling edge, updated after
    @(negedge clk); wrEn = 1'b1; addr = 6'(A_DRIVE); wrData = 32'hA5A5_5A5A;
    #1 chk("R12 before edge", out0, 32'h0);
    @(negedge clk); wrEn = 1'b0;
    chk("R12 after edge", out0, 32'hA5A5_5A5A);
    // R12 misaligned write ignored
    wr(A_DRIVE + 1, 32'hFFFF_FFFF);
    chk("R12 misaligned", out0, 32'hA5A5_5A5A);

    // R3/R4 random direction, mode, drive and pad patterns
    for (int it = 0; it < 24; it++) begin
      logic [31:0] drv, dir, mode, pad;
      drv = $urandom; dir = $urandom; mode = $urandom; pad = $urandom;
      if (it == 0) begin dir = '1; mode = '0; end
      wr(A_DRIVE, drv); wr(A_DIR, dir); wr(A_MODE, mode);
      padIn = pad; settle();
      chk("R3 padOut", out0, drv);
      chk("R3 padOe", oe0, expOe(dir, mode));
      rd(A_PADS, v); chk("R4 data read", v, expData(dir, drv, pad));
      // R1 narrow bank: upper pins inert
      chk("R1 narrow oe", oe1, expOe(dir, mode) & 32'hFF);
      chk("R1 narrow read", rd1, expData(dir, drv, pad) & 32'hFF);
    end
    wr(A_DIR, 0); wr(A_MODE, 0); wr(A_DRIVE, 0);
    padIn = 0; settle();

    // R5 enable set / mask semantics and readback
    wr(A_UNMASK, 32'h0000_00F0); rd(A_MASK, v); chk("R5 set", v, 32'h0000_00F0);
    wr(A_UNMASK, 32'h0000_0003); rd(A_MASK, v); chk("R5 set keeps", v, 32'h0000_00F3);
    wr(A_MASK, 32'hFFFF_FF0F);   rd(A_MASK, v); chk("R5 mask zeros", v, 32'h0000_0003);
    chk("R1 narrow enable", rd1, 32'h0000_0003);
    wr(A_UNMASK, 32'hFFFF_FFFF); @(negedge clk); addr = 6'(A_MASK); #1;
    chk("R1 zero count is 32 pins", rd0, 32'hFFFF_FFFF);
    chk("R1 narrow enable width", rd1, 32'h0000_00FF);
    rd(A_UNMASK, v); chk("R12 enable-set reads 0", v, 0);
    rd(A_ACK, v); chk("R12 clear reads 0", v, 0);
    wr(A_MASK, 32'h8000_0000);

    // R6 rising edge on pin 31
    wr(A_MODE, 32'h8000_0000); wr(A_EDGE, 32'h8000_0000); wr(A_ACK, '1);
    rd(A_STAT, v); chk("R6 idle", v, 0);
    padIn = 32'h8000_0000; settle();
    rd(A_STAT, v); chk("R6 rise", v, 32'h8000_0000);
    chk("R10 irq on", {31'b0, irq0}, 1);
    padIn = 0; settle();
    rd(A_STAT, v); chk("R6 latched", v, 32'h8000_0000);
    wr(A_ACK, 32'h4000_0000); rd(A_STAT, v); chk("R9 zero bits no effect", v, 32'h8000_0000);
    wr(A_ACK, 32'h8000_0000); rd(A_STAT, v); chk("R9 clear", v, 0);
    chk("R10 irq off", {31'b0, irq0}, 0);

    // R6 polarity 1 on pin 5: rise ignored, fall counts; enable gates irq
    wr(A_MODE, 32'h20); wr(A_EDGE, 32'h20); wr(A_POL, 32'h20); wr(A_ACK, '1);
    padIn = 32'h20; settle();
    rd(A_STAT, v); chk("R6 pol1 rise ignored", v, 0);
    padIn = 0; settle();
    rd(A_STAT, v); chk("R6 pol1 fall", v, 32'h20);
    chk("R10 masked", {31'b0, irq0}, 0);
    wr(A_UNMASK, 32'h20); chk("R10 unmasked", {31'b0, irq0}, 1);

    // R7 both edges with polarity 1 on pin 12
    wr(A_MODE, 32'h1000); wr(A_EDGE, 32'h1000); wr(A_BOTH, 32'h1000);
    wr(A_POL, 32'h1000); wr(A_ACK, '1);
    padIn = 32'h1000; settle(); rd(A_STAT, v); chk("R7 rise", v, 32'h1000);
    wr(A_ACK, '1);
    padIn = 0; settle(); rd(A_STAT, v); chk("R7 fall", v, 32'h1000);
    wr(A_BOTH, 0);

    // R8 active-low level on pin 3
    padIn = 32'h8; settle();
    wr(A_MODE, 32'h8); wr(A_EDGE, 0); wr(A_POL, 32'h8); wr(A_ACK, '1);
    rd(A_STAT, v); chk("R8 inactive", v, 0);
    padIn = 0; settle(); rd(A_STAT, v); chk("R8 active", v, 32'h8);
    wr(A_ACK, 32'h8); rd(A_STAT, v); chk("R8 clear while active", v, 32'h8);
    padIn = 32'h8; settle(); rd(A_STAT, v); chk("R8 follows", v, 0);

    // R11 GPIO-mode pin 20 ignores pad activity, no drive in interrupt mode
    wr(A_MODE, 0); wr(A_EDGE, 32'h10_0000); wr(A_POL, 0); wr(A_ACK, '1);
    padIn = 32'h10_0000; settle(); padIn = 0; settle();
    rd(A_STAT, v); chk("R11 gpio mode no status", v, 0);
    wr(A_DIR, 32'h10_0000); wr(A_MODE, 32'h10_0000);
    chk("R11 no drive in irq mode", oe0, 0);
    wr(A_DIR, 0);

    // R6/R7 random edge configurations
    for (int it = 0; it < 20; it++) begin
      int p; logic pol, both, s0;
      p = int'($urandom_range(31, 0)); pol = 1'($urandom); both = 1'($urandom); s0 = 1'($urandom);
      padIn = 32'(s0) << p; settle();
      wr(A_MODE, 32'h1 << p); wr(A_EDGE, 32'h1 << p);
      wr(A_POL, 32'(pol) << p); wr(A_BOTH, 32'(both) << p); wr(A_ACK, '1);
      padIn = 32'(~s0) << p; settle();
      rd(A_STAT, v);
      chk(both ? "R7 random" : "R6 random", v, 32'(expEvt(both, pol, s0, ~s0)) << p);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule